// File: doc/BRIEF.md
# Ethernet destination address filter

This block sits on the receive path of an Ethernet MAC and decides, frame by frame, whether a frame is kept or discarded, based only on its destination address. Received bytes arrive as a stream with first-byte and last-byte markers. The block stores the six destination-address bytes as they pass. It folds them into a 6-bit hash index at the same time. Once the frame is long enough to be legal, it gives a single-cycle verdict.

Software programs the filter through a 32-bit register port. The registers hold two exact-match station addresses, a 64-bit group hash table and a control word. The control word enables each station address, broadcast acceptance, and use of the hash table for individual addresses. The programmed state is copied when a frame starts, so a rewrite during a frame takes effect from the next frame.

Top module: `dafilt_top`

## Requirements
- R1: Registers sit at byte offsets 0x00/0x04 (station A low/high), 0x08/0x0C (station B low/high), 0x10/0x14 (hash table low/high) and 0x1C (control), with address bits 1:0 ignored. Reads return the last full 32-bit value written, on `reg_rdata` in the cycle after `reg_addr` is presented. Offset 0x18 reads as zero and ignores writes.
- R2: After reset every register reads zero, `dec_valid` is low, and a broadcast frame is dropped.
- R3: Destination byte 0 (first on the wire) is compared with low-register bits 7:0, bytes 1..3 with bits 15:8, 23:16 and 31:24, and bytes 4..5 with high-register bits 7:0 and 15:8. Control bit 0 enables station A and bit 1 enables station B, and an exact match on an enabled station accepts the frame.
- R4: With control bit 3 set, the destination ff:ff:ff:ff:ff:ff is accepted.
- R5: The hash index is the XOR of the eight 6-bit slices of the 48-bit destination, taken LSB-first from bit 0 of byte 0. Index 0..31 selects that bit of the table low register, and 32..63 selects bit (index-32) of the high register. A set bit accepts the frame.
- R6: The hash test counts only when bit 0 of destination byte 0 is set, unless control bit 2 is set.
- R7: A frame with fewer than 12 bytes is always dropped.
- R8: Exactly one single-cycle `dec_valid` pulse is produced per frame. It comes in the cycle after the 12th byte, or after the end-of-frame byte if the frame is shorter. `dec_accept` is meaningful only with it. Bytes with `rx_valid` low are ignored, and a start-of-frame byte abandons any unfinished frame.
- R9: The decision uses the register values held when the start-of-frame byte is taken. A write during the frame does not change that frame's verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_eof | input | 1 | Marks the last byte of a frame |
| dec_valid | output | 1 | One-cycle verdict strobe |
| dec_accept | output | 1 | Verdict: 1 keep, 0 drop |

## Verification
The bench builds the block with its defaults: a 5-bit register offset and a 12-byte minimum frame. With those values both edges of the length rule are reachable: frames of 5, 11 and 12 bytes, and the abandoned partial frame. The unused 0x18 slot also sits in the decoded range. Hash indexing is checked against a bench-side bitwise slice model, which sets only the predicted table bit and then every other bit. The all-ones and all-zero tables let the vector table check the multicast and individual-address rules without knowing the index.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAC_BYTES = 6;
  localparam int MAC_W     = MAC_BYTES * BYTE_W;
  localparam int HASH_W    = 6;
  localparam int REG_W     = 32;
  localparam int NSLOT     = 8;

  // register slot numbers (byte offset / 4)
  localparam int SLOT_STA_LO = 0;
  localparam int SLOT_STA_HI = 1;
  localparam int SLOT_STB_LO = 2;
  localparam int SLOT_STB_HI = 3;
  localparam int SLOT_GRP_LO = 4;
  localparam int SLOT_GRP_HI = 5;
  localparam int SLOT_HOLE   = 6;
  localparam int SLOT_CTRL   = 7;

  // control bit positions
  localparam int CB_STA   = 0;
  localparam int CB_STB   = 1;
  localparam int CB_INDIV = 2;
  localparam int CB_BCAST = 3;

  typedef logic [MAC_W-1:0] mac_t;

  typedef struct packed {
    mac_t                 sta_a;
    mac_t                 sta_b;
    logic [2*REG_W-1:0]   grp;
    logic [3:0]           ctrl;
  } filt_cfg_t;

  // Spread one byte over the 6-bit hash, starting at position rot.
  function automatic logic [HASH_W-1:0] fold_byte(input logic [BYTE_W-1:0] b,
                                                  input int rot);
    logic [HASH_W-1:0] h;
    logic [2:0]        p;
    h = '0;
    for (int k = 0; k < BYTE_W; k++) begin
      p    = 3'((rot + k) % HASH_W);
      h[p] = h[p] ^ b[k];
    end
    return h;
  endfunction
endpackage

// File: rtl/dafilt_regs.sv
module dafilt_regs
  import dafilt_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [REG_AW-1:0]  addr,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  output filt_cfg_t          cfg
);
  localparam int IDX_W = REG_AW - 2;

  logic [REG_W-1:0] slot_q [NSLOT];
  logic [IDX_W-1:0] idx;
  logic             mapped;
  logic [2:0]       sel;

  assign idx    = addr[REG_AW-1:2];
  assign sel    = idx[2:0];
  assign mapped = (idx < IDX_W'(SLOT_HOLE)) || (idx == IDX_W'(SLOT_CTRL));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
      rdata <= '0;
    end else begin
      if (we && mapped) slot_q[sel] <= wdata;
      rdata <= mapped ? slot_q[sel] : '0;
    end
  end

  assign cfg.sta_a = {slot_q[SLOT_STA_HI][15:0], slot_q[SLOT_STA_LO]};
  assign cfg.sta_b = {slot_q[SLOT_STB_HI][15:0], slot_q[SLOT_STB_LO]};
  assign cfg.grp   = {slot_q[SLOT_GRP_HI], slot_q[SLOT_GRP_LO]};
  assign cfg.ctrl  = slot_q[SLOT_CTRL][3:0];
endmodule

// File: rtl/dafilt_capture.sv
module dafilt_capture
  import dafilt_pkg::*;
#(
  parameter int MIN_FRAME = 12   // must exceed MAC_BYTES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [BYTE_W-1:0]  in_data,
  input  logic               in_sof,
  input  logic               in_eof,
  output logic               take_sof,
  output logic               fire_full,
  output logic               fire_short,
  output mac_t               da,
  output logic [HASH_W-1:0]  hash
);
  localparam int CNT_W = $clog2(MIN_FRAME + 1);

  logic [CNT_W-1:0]  cnt_q, nxt;
  logic              busy_q, live;
  logic [HASH_W-1:0] hash_q, hash_d;
  mac_t              da_q;

  assign live       = in_valid && (in_sof || busy_q);
  assign nxt        = in_sof ? CNT_W'(1) : cnt_q + CNT_W'(1);
  assign take_sof   = in_valid && in_sof;
  assign fire_full  = live && (nxt == CNT_W'(MIN_FRAME));
  assign fire_short = live && in_eof && (nxt < CNT_W'(MIN_FRAME));

  always_comb begin
    hash_d = in_sof ? '0 : hash_q;
    for (int g = 0; g < MAC_BYTES; g++)
      if (nxt == CNT_W'(g + 1)) hash_d = hash_d ^ fold_byte(in_data, (2 * g) % HASH_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      hash_q <= '0;
    end else if (live) begin
      cnt_q  <= nxt;
      busy_q <= !(fire_full || in_eof);
      hash_q <= hash_d;
    end
  end

  for (genvar g = 0; g < MAC_BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) da_q[BYTE_W*g +: BYTE_W] <= '0;
      else if (live && nxt == CNT_W'(g + 1)) da_q[BYTE_W*g +: BYTE_W] <= in_data;
    end
  end

  assign da   = da_q;
  assign hash = hash_q;
endmodule

// File: rtl/dafilt_decide.sv
module dafilt_decide
  import dafilt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  filt_cfg_t          cfg,
  input  logic               take_sof,
  input  logic               fire_full,
  input  logic               fire_short,
  input  mac_t               da,
  input  logic [HASH_W-1:0]  hash,
  output logic               dec_valid,
  output logic               dec_accept
);
  filt_cfg_t snap_q;
  logic      hit_a, hit_b, hit_bc, hit_grp, hit;

  always_ff @(posedge clk) begin
    if (rst) snap_q <= '0;
    else if (take_sof) snap_q <= cfg;
  end

  assign hit_a   = snap_q.ctrl[CB_STA] && (da == snap_q.sta_a);
  assign hit_b   = snap_q.ctrl[CB_STB] && (da == snap_q.sta_b);
  assign hit_bc  = snap_q.ctrl[CB_BCAST] && (&da);
  assign hit_grp = (da[0] || snap_q.ctrl[CB_INDIV]) && snap_q.grp[hash];
  assign hit     = hit_a || hit_b || hit_bc || hit_grp;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= fire_full || fire_short;
      dec_accept <= fire_full && hit;
    end
  end
endmodule

// File: rtl/dafilt_top.sv
module dafilt_top
  import dafilt_pkg::*;
#(
  parameter int REG_AW    = 5,
  parameter int MIN_FRAME = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               rx_valid,
  input  logic [7:0]         rx_data,
  input  logic               rx_sof,
  input  logic               rx_eof,
  output logic               dec_valid,
  output logic               dec_accept
);
  filt_cfg_t         cfg;
  logic              take_sof, fire_full, fire_short;
  mac_t              da;
  logic [HASH_W-1:0] hash;

  dafilt_regs #(.REG_AW(REG_AW)) regs_i (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg)
  );

  dafilt_capture #(.MIN_FRAME(MIN_FRAME)) cap_i (
    .clk(clk), .rst(rst), .in_valid(rx_valid), .in_data(rx_data),
    .in_sof(rx_sof), .in_eof(rx_eof), .take_sof(take_sof),
    .fire_full(fire_full), .fire_short(fire_short), .da(da), .hash(hash)
  );

  dafilt_decide dec_i (
    .clk(clk), .rst(rst), .cfg(cfg), .take_sof(take_sof),
    .fire_full(fire_full), .fire_short(fire_short), .da(da), .hash(hash),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );
endmodule

// File: rtl/dafilt_chk.sv
module dafilt_chk #(
  parameter int REG_AW    = 5,
  parameter int MIN_FRAME = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_we,
  input logic [REG_AW-1:0]  reg_addr,
  input logic [31:0]        reg_wdata,
  input logic [31:0]        reg_rdata,
  input logic               rx_valid,
  input logic               rx_sof,
  input logic               rx_eof,
  input logic               dec_valid,
  input logic               dec_accept
);
  logic [7:0] len_q;
  logic       inframe_q, decided_q, wr_mapped;
  logic [REG_AW-3:0] widx;

  assign widx      = reg_addr[REG_AW-1:2];
  assign wr_mapped = (widx < (REG_AW-2)'(6)) || (widx == (REG_AW-2)'(7));

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0; inframe_q <= 1'b0; decided_q <= 1'b0;
    end else begin
      if (rx_valid && rx_sof) begin
        len_q <= 8'd1; inframe_q <= !rx_eof;
      end else if (rx_valid && inframe_q) begin
        if (len_q != 8'hFF) len_q <= len_q + 8'd1;
        if (rx_eof) inframe_q <= 1'b0;
      end
      if (rx_valid && rx_sof) decided_q <= 1'b0;
      else if (dec_valid)     decided_q <= 1'b1;
    end
  end

  AST_READBACK: assert property (@(posedge clk) disable iff (rst)
    (reg_we && wr_mapped) ##1 (reg_addr == $past(reg_addr)) |=> (reg_rdata == $past(reg_wdata, 2))); // R1
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dec_valid); // R2
  AST_SHORT_DROP: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && len_q < 8'(MIN_FRAME)) |-> !dec_accept); // R7
  AST_ACCEPT_QUAL: assert property (@(posedge clk) disable iff (rst)
    dec_accept |-> dec_valid); // R8
  AST_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(rx_valid)); // R8
  AST_ONE_PER_FRAME: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> !decided_q); // R8
endmodule

bind dafilt_top dafilt_chk #(.REG_AW(REG_AW), .MIN_FRAME(MIN_FRAME)) chk_i (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
  .rx_sof(rx_sof), .rx_eof(rx_eof), .dec_valid(dec_valid),
  .dec_accept(dec_accept)
);

// File: tb/dafilt_tb.sv
`timescale 1ns/1ps
module dafilt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        rx_valid, rx_sof, rx_eof;
  logic [7:0]  rx_data;
  logic        dec_valid, dec_accept;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dafilt_top dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  localparam logic [47:0] MAC_A = 48'h021122334455; // wire order, byte 0 leftmost
  localparam logic [47:0] MAC_B = 48'h02aabbccddee;
  localparam logic [47:0] BCAST = 48'hffffffffffff;

  // {ctrl[3:0], table_all_ones, dest (wire order), length, expect_accept}
  localparam int NV = 14;
  localparam logic [61:0] VEC [NV] = '{
    {4'h1, 1'b0, MAC_A,           8'd20, 1'b1}, // R3 station A
    {4'h0, 1'b0, MAC_A,           8'd20, 1'b0}, // R3 station A disabled
    {4'h2, 1'b0, MAC_B,           8'd20, 1'b1}, // R3 station B
    {4'h1, 1'b0, MAC_B,           8'd20, 1'b0}, // R3 wrong station enabled
    {4'h8, 1'b0, BCAST,           8'd20, 1'b1}, // R4 broadcast on
    {4'h0, 1'b0, BCAST,           8'd20, 1'b0}, // R4 broadcast off
    {4'h0, 1'b1, 48'h01005e000001, 8'd20, 1'b1}, // R6 multicast via table
    {4'h0, 1'b1, MAC_A,           8'd20, 1'b0}, // R6 individual, bit 2 off
    {4'h4, 1'b1, MAC_A,           8'd20, 1'b1}, // R6 individual, bit 2 on
    {4'h1, 1'b0, MAC_A,           8'd11, 1'b0}, // R7 one byte short
    {4'h1, 1'b0, MAC_A,           8'd12, 1'b1}, // R7 exactly minimum
    {4'h3, 1'b0, 48'h021122334456, 8'd20, 1'b0}, // R3 last byte differs
    {4'h8, 1'b1, BCAST,           8'd5,  1'b0}, // R7 shorter than address
    {4'h0, 1'b1, BCAST,           8'd20, 1'b1}  // R6 broadcast through table
  };

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  function automatic logic [5:0] ref_hash(input logic [47:0] wire_da);
    logic [47:0] v;
    logic [5:0]  h;
    for (int i = 0; i < 6; i++) v[8*i +: 8] = wire_da[47-8*i -: 8];
    h = '0;
    for (int j = 0; j < 8; j++) h = h ^ v[6*j +: 6];
    return h;
  endfunction

  task automatic send(input logic [47:0] wire_da, input int len, input logic gap,
                      input logic noeof, input int wr_at, input logic [31:0] wr_val,
                      output int pulses, output int pos, output logic acc);
    int done;
    pulses = 0; pos = -1; acc = 1'b0; done = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (dec_valid) begin pulses++; pos = done; acc = dec_accept; end
      reg_we = 1'b0;
      if (gap && i > 0) begin
        rx_valid = 1'b0; rx_sof = 1'b1; rx_data = 8'hff;   // ignored cycle
        @(negedge clk);
        if (dec_valid) begin pulses++; pos = done; acc = dec_accept; end
      end
      rx_valid = 1'b1;
      rx_sof   = (i == 0);
      rx_eof   = (i == len - 1) && !noeof;
      rx_data  = (i < 6) ? wire_da[47-8*i -: 8] : 8'(i * 7 + 3);
      if (i == wr_at) begin reg_we = 1'b1; reg_addr = 5'h1C; reg_wdata = wr_val; end
      done++;
    end
    @(negedge clk);
    if (dec_valid) begin pulses++; pos = done; acc = dec_accept; end
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; reg_we = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (dec_valid) begin pulses++; pos = done; acc = dec_accept; end
    end
  endtask

  task automatic frame_check(input string req, input logic [47:0] wire_da, input int len,
                             input logic gap, input int wr_at, input logic [31:0] wr_val,
                             input logic exp);
    int p, ps; logic a; int ep;
    send(wire_da, len, gap, 1'b0, wr_at, wr_val, p, ps, a);
    ep = (len < 12) ? len : 12;
    check(p == 1,  {req, " pulse count"}, 64'(p), 64'd1);
    check(ps == ep, {req, " verdict position"}, 64'(ps), 64'(ep));
    check(a == exp, {req, " verdict"}, 64'(a), 64'(exp));
  endtask

  task automatic set_table(input logic [63:0] t);
    wr(5'h10, t[31:0]); wr(5'h14, t[63:32]);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int p, ps; logic a;
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    check(dec_valid == 1'b0, "R2 dec_valid after reset", 64'(dec_valid), 64'd0);
    for (int s = 0; s < 8; s++) begin
      rd(5'(4 * s), d);
      check(d == 32'd0, "R2 register reset value", 64'(d), 64'd0);
    end
    frame_check("R2 cleared filter drops broadcast", BCAST, 20, 1'b0, -1, 32'd0, 1'b0);

    // R1 write/readback, hole at 0x18
    for (int s = 0; s < 8; s++) wr(5'(4 * s), 32'hA5000000 | 32'(s * 32'h01010101));
    for (int s = 0; s < 8; s++) begin
      rd(5'(4 * s + 2), d);   // low address bits ignored
      if (s == 6) check(d == 32'd0, "R1 unused offset reads zero", 64'(d), 64'd0);
      else check(d == (32'hA5000000 | 32'(s * 32'h01010101)), "R1 readback",
                 64'(d), 64'(32'hA5000000 | 32'(s * 32'h01010101)));
    end

    // program stations (R3 byte order)
    wr(5'h00, 32'h33221102); wr(5'h04, 32'h00005544);
    wr(5'h08, 32'hccbbaa02); wr(5'h0C, 32'h0000eedd);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [61:0] e;
      e = VEC[v];
      wr(5'h1C, {28'd0, e[61:58]});
      set_table(e[57] ? 64'hffffffffffffffff : 64'd0);
      frame_check($sformatf("vector %0d", v), e[56:9], int'(e[8:1]), 1'b0, -1, 32'd0, e[0]);
    end

    // R5 hash indexing: only the predicted bit, then every other bit
    wr(5'h1C, 32'd0);
    for (int t = 0; t < 4; t++) begin
      logic [47:0] m;
      logic [5:0]  h;
      case (t)
        0: m = 48'h01005e000001;
        1: m = 48'h333300000001;
        2: m = 48'h0180c2000000;
        default: m = 48'h01ffffff0000;
      endcase
      h = ref_hash(m);
      set_table(64'd1 << h);
      frame_check("R5 predicted table bit", m, 16, 1'b0, -1, 32'd0, 1'b1);
      set_table(~(64'd1 << h));
      frame_check("R5 other table bits", m, 16, 1'b0, -1, 32'd0, 1'b0);
    end
    set_table(64'd0);

    // R9 mid-frame control write
    wr(5'h1C, 32'h1);
    frame_check("R9 disable during frame", MAC_A, 20, 1'b0, 3, 32'h0, 1'b1);
    frame_check("R9 disable seen next frame", MAC_A, 20, 1'b0, -1, 32'd0, 1'b0);
    frame_check("R9 enable during frame", MAC_A, 20, 1'b0, 2, 32'h1, 1'b0);
    frame_check("R9 enable seen next frame", MAC_A, 20, 1'b0, -1, 32'd0, 1'b1);

    // R8 idle gaps with a stray start marker while valid is low
    frame_check("R8 gaps ignored", MAC_A, 14, 1'b1, -1, 32'd0, 1'b1);

    // R8 abandoned partial frame then a full one
    send(MAC_A, 8, 1'b0, 1'b1, -1, 32'd0, p, ps, a);
    check(p == 0, "R8 partial frame gives no verdict", 64'(p), 64'd0);
    frame_check("R8 restart after partial", MAC_A, 13, 1'b0, -1, 32'd0, 1'b1);

    // R7 single-byte frame
    frame_check("R7 one-byte frame", MAC_A, 1, 1'b0, -1, 32'd0, 1'b0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule